// File: doc/BRIEF.md
# Radio MAC Sequencer Controller

This block is the control core of a low-rate 2.4 GHz packet radio MAC. Software starts a receive, transmit, energy-detect or clear-channel sequence, or an idle no-op, by writing a sequence code. The controller tracks the active mode and collects interrupt sources from the modelled radio into a status register. A mask gates that register onto one interrupt line, and software clears bits by writing ones.

Several radio events are handled directly in hardware. A transmit completion is turned into a link-level result and is followed at once by an abort and a return to receive with frame filtering on. An energy-detect completion re-arms the scan. A frame match during receive loads the outgoing acknowledgement pending bit. The abort procedure is a fixed walk of single-cycle steps. The divider is held at its minimum while the state machines pass through synchronous reset, and each register is changed in a set order.

Top module: `mac_seq_ctrl`

## Requirements
- R1: After reset: mode off (0), sequence 0, mask 0, status 0, `irq_o` low, control word 2, divider `DIV_RST` (15), timers disarmed, filters off, `busy_o` low, no transmit result.
- R2: Writing address 0 with 0, 3, 4, 5 or 6 loads that sequence code and sets the mode to off (0), receive (1), transmit (2), energy detect (3) or clear-channel (4). `seq_start_o` pulses for one cycle on a nonzero code. Any other value is ignored.
- R3: Radio events set status bits: 0 complete, 1 started, 2 data, 3 frame start, 4 packet fail, 5 frame match. `irq_o` is the OR of status AND mask, and the mask is at address 1. Writing ones to address 2 clears status bits, so 0x3F clears all. An event wins over a clear of the same bit in the same cycle. Status reads back at address 2.
- R4: A write to address 5 starts an abort, with one step per clock from the write edge. Edge 1 saves the divider. Edge 2 sets the divider to 1. Edge 3 sets the mask to 0. Edge 4 clears the status. Edge 5 loads sequence 0. Edge 6 sets control word 3. Edge 7 sets control word 2. Edge 8 disarms the timers and clears the filters. Edge 9 restores the divider. `busy_o` falls at edge 10.
- R5: An abort overrides a completion that arrives in the same cycle, and no transmit result is produced. After a software abort the mode is off. While `busy_o` is high, register writes and radio events are ignored.
- R6: A completion in transmit mode produces `tx_res_vld_o` for one cycle, with the result on `tx_res_o`. Code 0 gives done (1) if option bit 0 (ack requested) is set, else success (0). Code 8 gives done-pending (2). Code 2 gives channel-busy fail (3). Every other code gives fail (4).
- R7: After a transmit completion the controller runs the R4 abort and then enters receive. It loads sequence 3, mask 0x25 and filter enables 7, and pulses `seq_start_o`.
- R8: A completion in energy-detect mode re-arms the scan. The sequence stays 5, the mask becomes 0x01, status bit 0 stays clear and `seq_start_o` pulses.
- R9: A frame match in receive mode sets `ack_pend_o` to option bit 1 and sets `ack_ovr_o`, and status bit 5 is not kept. In other modes a frame match only sets status bit 5. The abort clears both outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Write address |
| wr_data | input | DATA_W | Write data |
| rd_addr | input | ADDR_W | Read address |
| rd_data | output | DATA_W | Read data: 0 seq, 1 mask, 2 status, 3 divider, 4 options, 6 last result |
| radio_evt | input | NSRC | Radio event pulses, one per interrupt source |
| radio_code | input | 4 | Radio status code that goes with a completion |
| irq_o | output | 1 | Masked interrupt |
| mode_o | output | 3 | Tracked mode |
| seq_o | output | 3 | Current sequence code |
| seq_start_o | output | 1 | Sequence launched pulse |
| mask_o | output | NSRC | Interrupt mask |
| div_o | output | DIV_W | Clock divider register |
| ctrl_o | output | 2 | Control word (bit 0 sync reset, bit 1 on) |
| tmr_arm_o | output | 1 | Start/stop timers armed (option bit 2) |
| flt_o | output | 3 | Beacon/data/command filter enables (option bits 5:3) |
| busy_o | output | 1 | Abort in progress |
| tx_res_vld_o | output | 1 | Transmit result strobe |
| tx_res_o | output | 3 | Transmit result |
| ack_pend_o | output | 1 | Outgoing ack pending bit |
| ack_ovr_o | output | 1 | Ack pending override |

## Verification
The hardest state to reach is the inside of the abort walk, where a set of registers changes one at a time over ten cycles with nothing else moving. The stimulus first loads a random divider and mask, sets status bits and arms the timers. It then starts the abort and takes a snapshot at every cycle, so an early, late or swapped step shows up against a per-cycle expectation. An abort that collides with a transmit completion in the same cycle is driven on one falling edge. All sixteen completion codes are swept with the acknowledgement flag both clear and set.

// File: rtl/mac_seq_pkg.sv
package mac_seq_pkg;

  localparam logic [2:0] SEQ_NOP = 3'd0;
  localparam logic [2:0] SEQ_RX  = 3'd3;
  localparam logic [2:0] SEQ_TX  = 3'd4;
  localparam logic [2:0] SEQ_ED  = 3'd5;
  localparam logic [2:0] SEQ_CCA = 3'd6;

  localparam logic [3:0] ST_SUCCESS    = 4'h0;
  localparam logic [3:0] ST_BUSY       = 4'h2;
  localparam logic [3:0] ST_RXACK_PEND = 4'h8;

  localparam int IRQ_COMPLETE = 0;
  localparam int IRQ_DATA     = 2;
  localparam int IRQ_MATCH    = 5;

  typedef enum logic [2:0] {
    MODE_OFF = 3'd0,
    MODE_RX  = 3'd1,
    MODE_TX  = 3'd2,
    MODE_ED  = 3'd3,
    MODE_CCA = 3'd4
  } mode_e;

  typedef enum logic [2:0] {
    RES_SUCCESS   = 3'd0,
    RES_DONE      = 3'd1,
    RES_DONE_PEND = 3'd2,
    RES_CCA_FAIL  = 3'd3,
    RES_FAIL      = 3'd4
  } tx_res_e;

  typedef enum logic [3:0] {
    AB_IDLE = 4'd0,
    AB_SAVE = 4'd1,
    AB_DIV1 = 4'd2,
    AB_MASK = 4'd3,
    AB_CLR  = 4'd4,
    AB_NOP  = 4'd5,
    AB_RST  = 4'd6,
    AB_REL  = 4'd7,
    AB_TMR  = 4'd8,
    AB_REST = 4'd9,
    AB_FIN  = 4'd10
  } ab_step_e;

endpackage

// File: rtl/mac_seq_txmap.sv
module mac_seq_txmap
  import mac_seq_pkg::*;
(
  input  logic [3:0] code_i,
  input  logic       ack_req_i,
  output tx_res_e    res_o
);

  always_comb begin
    case (code_i)
      ST_SUCCESS:    res_o = ack_req_i ? RES_DONE : RES_SUCCESS;
      ST_RXACK_PEND: res_o = RES_DONE_PEND;
      ST_BUSY:       res_o = RES_CCA_FAIL;
      default:       res_o = RES_FAIL;
    endcase
  end

endmodule

// File: rtl/mac_seq_abort.sv
module mac_seq_abort
  import mac_seq_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     start_i,
  input  logic     restart_i,
  output ab_step_e step_o,
  output logic     restart_o
);

  ab_step_e state_q, state_d;
  logic     restart_q, restart_d;

  always_comb begin
    state_d   = state_q;
    restart_d = restart_q;
    if (state_q == AB_IDLE) begin
      if (start_i) begin
        state_d   = AB_SAVE;
        restart_d = restart_i;
      end
    end else if (state_q == AB_FIN) begin
      state_d = AB_IDLE;
    end else begin
      state_d = ab_step_e'(state_q + 4'd1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= AB_IDLE;
      restart_q <= 1'b0;
    end else begin
      state_q   <= state_d;
      restart_q <= restart_d;
    end
  end

  assign step_o    = state_q;
  assign restart_o = restart_q;

  // R4
  step_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q != AB_IDLE && state_q != AB_FIN) |=> (state_q == ab_step_e'($past(state_q) + 4'd1)));

endmodule

// File: rtl/mac_seq_irq.sv
module mac_seq_irq #(
  parameter int NSRC = 6
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] set_i,
  input  logic [NSRC-1:0] w1c_i,
  input  logic [NSRC-1:0] hw_clr_i,
  input  logic [NSRC-1:0] mask_i,
  output logic [NSRC-1:0] status_o,
  output logic            irq_o
);

  logic [NSRC-1:0] st_q, st_d;

  for (genvar i = 0; i < NSRC; i++) begin : g_src
    always_comb begin
      if (hw_clr_i[i])    st_d[i] = 1'b0;
      else if (set_i[i])  st_d[i] = 1'b1;
      else if (w1c_i[i])  st_d[i] = 1'b0;
      else                st_d[i] = st_q[i];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) st_q[i] <= 1'b0;
      else        st_q[i] <= st_d[i];
    end
  end

  assign status_o = st_q;
  assign irq_o    = |(st_q & mask_i);

  // R3
  set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (set_i != '0 && (set_i & hw_clr_i) == '0) |=> ((st_q & $past(set_i & ~hw_clr_i)) == $past(set_i & ~hw_clr_i)));

endmodule

// File: rtl/mac_seq_ctrl.sv
module mac_seq_ctrl
  import mac_seq_pkg::*;
#(
  parameter int              ADDR_W  = 3,
  parameter int              DATA_W  = 8,
  parameter int              NSRC    = 6,
  parameter int              DIV_W   = 8,
  parameter logic [DIV_W-1:0] DIV_RST = 8'd15
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  input  logic [NSRC-1:0]   radio_evt,
  input  logic [3:0]        radio_code,
  output logic              irq_o,
  output logic [2:0]        mode_o,
  output logic [2:0]        seq_o,
  output logic              seq_start_o,
  output logic [NSRC-1:0]   mask_o,
  output logic [DIV_W-1:0]  div_o,
  output logic [1:0]        ctrl_o,
  output logic              tmr_arm_o,
  output logic [2:0]        flt_o,
  output logic              busy_o,
  output logic              tx_res_vld_o,
  output logic [2:0]        tx_res_o,
  output logic              ack_pend_o,
  output logic              ack_ovr_o
);

  localparam int SEQ_W   = 3;
  localparam int OPT_W   = 6;
  localparam int OPT_ACK = 0;
  localparam int OPT_PND = 1;
  localparam int OPT_TMR = 2;
  localparam int OPT_FLT = 3;
  localparam logic [ADDR_W-1:0] A_SEQ = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] A_MSK = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] A_STS = ADDR_W'(2);
  localparam logic [ADDR_W-1:0] A_DIV = ADDR_W'(3);
  localparam logic [ADDR_W-1:0] A_OPT = ADDR_W'(4);
  localparam logic [ADDR_W-1:0] A_ABT = ADDR_W'(5);
  localparam logic [ADDR_W-1:0] A_RES = ADDR_W'(6);
  localparam logic [NSRC-1:0] ALL_SRC = {NSRC{1'b1}};
  localparam logic [NSRC-1:0] ED_MASK = NSRC'(1) << IRQ_COMPLETE;
  localparam logic [NSRC-1:0] RX_MASK = (NSRC'(1) << IRQ_COMPLETE) |
                                        (NSRC'(1) << IRQ_DATA) |
                                        (NSRC'(1) << IRQ_MATCH);
  localparam logic [1:0] CTRL_ON  = 2'd2;
  localparam logic [1:0] CTRL_RST = 2'd3;

  // state
  mode_e            mode_q, mode_d;
  logic [SEQ_W-1:0] seq_q, seq_d;
  logic [NSRC-1:0]  mask_q, mask_d;
  logic [DIV_W-1:0] div_q, div_d, saved_q, saved_d;
  logic [1:0]       ctrl_q, ctrl_d;
  logic [OPT_W-1:0] opt_q, opt_d;
  logic             seq_start_q, seq_start_d;
  logic             tx_vld_q, tx_vld_d;
  tx_res_e          res_q, res_d;
  logic             ack_pend_q, ack_pend_d, ack_ovr_q, ack_ovr_d;

  ab_step_e         ab_step;
  logic             ab_restart;
  tx_res_e          res_map;
  logic [NSRC-1:0]  status, hw_clr, w1c, evt_ok;
  logic             busy, wr_ok, abort_req, seq_wr, seq_code_ok;
  logic             done, tx_done, ed_done, fm_hit;

  function automatic mode_e mode_of(input logic [SEQ_W-1:0] c);
    case (c)
      SEQ_RX:  return MODE_RX;
      SEQ_TX:  return MODE_TX;
      SEQ_ED:  return MODE_ED;
      SEQ_CCA: return MODE_CCA;
      default: return MODE_OFF;
    endcase
  endfunction

  // decode
  assign busy        = (ab_step != AB_IDLE);
  assign wr_ok       = wr_en && !busy;
  assign abort_req   = wr_ok && (wr_addr == A_ABT);
  assign seq_code_ok = (wr_data[DATA_W-1:SEQ_W] == '0) &&
                       (wr_data[SEQ_W-1:0] inside {SEQ_NOP, SEQ_RX, SEQ_TX, SEQ_ED, SEQ_CCA});
  assign seq_wr      = wr_ok && (wr_addr == A_SEQ) && seq_code_ok;
  assign evt_ok      = busy ? '0 : radio_evt;
  assign done        = evt_ok[IRQ_COMPLETE] && !abort_req;
  assign tx_done     = done && (mode_q == MODE_TX);
  assign ed_done     = done && (mode_q == MODE_ED);
  assign fm_hit      = evt_ok[IRQ_MATCH] && (mode_q == MODE_RX) && !abort_req;
  assign w1c         = (wr_ok && wr_addr == A_STS) ? wr_data[NSRC-1:0] : '0;
  assign hw_clr      = ((ab_step == AB_CLR) ? ALL_SRC : '0) |
                       (ed_done ? ED_MASK : '0) |
                       (fm_hit ? (NSRC'(1) << IRQ_MATCH) : '0);

  mac_seq_abort u_abort (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_i   (abort_req || tx_done),
    .restart_i (tx_done),
    .step_o    (ab_step),
    .restart_o (ab_restart)
  );

  mac_seq_txmap u_txmap (
    .code_i    (radio_code),
    .ack_req_i (opt_q[OPT_ACK]),
    .res_o     (res_map)
  );

  mac_seq_irq #(.NSRC(NSRC)) u_irq (
    .clk      (clk),
    .rst_n    (rst_n),
    .set_i    (evt_ok),
    .w1c_i    (w1c),
    .hw_clr_i (hw_clr),
    .mask_i   (mask_q),
    .status_o (status),
    .irq_o    (irq_o)
  );

  // next state
  always_comb begin
    mode_d      = mode_q;
    seq_d       = seq_q;
    mask_d      = mask_q;
    div_d       = div_q;
    saved_d     = saved_q;
    ctrl_d      = ctrl_q;
    opt_d       = opt_q;
    seq_start_d = 1'b0;
    tx_vld_d    = 1'b0;
    res_d       = res_q;
    ack_pend_d  = ack_pend_q;
    ack_ovr_d   = ack_ovr_q;

    if (seq_wr) begin
      seq_d       = wr_data[SEQ_W-1:0];
      mode_d      = mode_of(wr_data[SEQ_W-1:0]);
      seq_start_d = (wr_data[SEQ_W-1:0] != SEQ_NOP);
    end
    if (wr_ok && wr_addr == A_MSK) mask_d = wr_data[NSRC-1:0];
    if (wr_ok && wr_addr == A_DIV) div_d  = wr_data[DIV_W-1:0];
    if (wr_ok && wr_addr == A_OPT) opt_d  = wr_data[OPT_W-1:0];

    if (tx_done) begin
      tx_vld_d = 1'b1;
      res_d    = res_map;
    end
    if (ed_done) begin
      mask_d      = ED_MASK;
      seq_d       = SEQ_ED;
      seq_start_d = 1'b1;
    end
    if (fm_hit) begin
      ack_pend_d = opt_q[OPT_PND];
      ack_ovr_d  = 1'b1;
    end

    case (ab_step)
      AB_SAVE: saved_d = div_q;
      AB_DIV1: div_d   = DIV_W'(1);
      AB_MASK: mask_d  = '0;
      AB_NOP:  seq_d   = SEQ_NOP;
      AB_RST: begin
        ctrl_d     = CTRL_RST;
        ack_pend_d = 1'b0;
        ack_ovr_d  = 1'b0;
      end
      AB_REL:  ctrl_d  = CTRL_ON;
      AB_TMR: begin
        opt_d[OPT_TMR]           = 1'b0;
        opt_d[OPT_FLT +: 3]      = 3'b000;
      end
      AB_REST: div_d   = saved_q;
      AB_FIN: begin
        if (ab_restart) begin
          opt_d[OPT_FLT +: 3] = 3'b111;
          mask_d              = RX_MASK;
          seq_d               = SEQ_RX;
          mode_d              = MODE_RX;
          seq_start_d         = 1'b1;
        end else begin
          mode_d = MODE_OFF;
        end
      end
      default: ;
    endcase
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q      <= MODE_OFF;
      seq_q       <= SEQ_NOP;
      mask_q      <= '0;
      div_q       <= DIV_RST;
      saved_q     <= DIV_RST;
      ctrl_q      <= CTRL_ON;
      opt_q       <= '0;
      seq_start_q <= 1'b0;
      tx_vld_q    <= 1'b0;
      res_q       <= RES_SUCCESS;
      ack_pend_q  <= 1'b0;
      ack_ovr_q   <= 1'b0;
    end else begin
      mode_q      <= mode_d;
      seq_q       <= seq_d;
      mask_q      <= mask_d;
      div_q       <= div_d;
      if (ab_step == AB_SAVE) saved_q <= saved_d;
      ctrl_q      <= ctrl_d;
      opt_q       <= opt_d;
      seq_start_q <= seq_start_d;
      tx_vld_q    <= tx_vld_d;
      if (tx_done) res_q <= res_d;
      ack_pend_q  <= ack_pend_d;
      ack_ovr_q   <= ack_ovr_d;
    end
  end

  // read port
  always_comb begin
    case (rd_addr)
      A_SEQ:   rd_data = DATA_W'(seq_q);
      A_MSK:   rd_data = DATA_W'(mask_q);
      A_STS:   rd_data = DATA_W'(status);
      A_DIV:   rd_data = DATA_W'(div_q);
      A_OPT:   rd_data = DATA_W'(opt_q);
      A_RES:   rd_data = DATA_W'(res_q);
      default: rd_data = '0;
    endcase
  end

  assign mode_o       = mode_q;
  assign seq_o        = seq_q;
  assign seq_start_o  = seq_start_q;
  assign mask_o       = mask_q;
  assign div_o        = div_q;
  assign ctrl_o       = ctrl_q;
  assign tmr_arm_o    = opt_q[OPT_TMR];
  assign flt_o        = opt_q[OPT_FLT +: 3];
  assign busy_o       = busy;
  assign tx_res_vld_o = tx_vld_q;
  assign tx_res_o     = res_q;
  assign ack_pend_o   = ack_pend_q;
  assign ack_ovr_o    = ack_ovr_q;

  // R4
  div_min_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_q == CTRL_RST) |-> (div_q == DIV_W'(1) && mask_q == '0 && busy));

  // R7
  tx_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_vld_q |-> busy);

  // R5
  tx_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> !tx_vld_q);

  // R8
  ed_rearm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == MODE_ED && evt_ok[IRQ_COMPLETE] && !abort_req) |=> (mask_q == ED_MASK && seq_start_q));

  // R2
  seq_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    seq_start_q |-> (seq_q != SEQ_NOP));

  // R9
  ovr_rx_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ack_ovr_q) |-> ($past(mode_q) == MODE_RX));

endmodule

// File: tb/mac_seq_ctrl_tb.sv
module mac_seq_ctrl_tb;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       wr_en;
  logic [2:0] wr_addr;
  logic [7:0] wr_data;
  logic [2:0] rd_addr;
  logic [7:0] rd_data;
  logic [5:0] radio_evt;
  logic [3:0] radio_code;
  logic       irq_o, seq_start_o, tmr_arm_o, busy_o, tx_res_vld_o, ack_pend_o, ack_ovr_o;
  logic [2:0] mode_o, seq_o, flt_o, tx_res_o;
  logic [5:0] mask_o;
  logic [7:0] div_o;
  logic [1:0] ctrl_o;

  int checks = 0;
  int errors = 0;
  bit ended  = 0;

  always #5 clk = ~clk;

  mac_seq_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .radio_evt(radio_evt), .radio_code(radio_code),
    .irq_o(irq_o), .mode_o(mode_o), .seq_o(seq_o), .seq_start_o(seq_start_o),
    .mask_o(mask_o), .div_o(div_o), .ctrl_o(ctrl_o), .tmr_arm_o(tmr_arm_o),
    .flt_o(flt_o), .busy_o(busy_o), .tx_res_vld_o(tx_res_vld_o), .tx_res_o(tx_res_o),
    .ack_pend_o(ack_pend_o), .ack_ovr_o(ack_ovr_o)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  function automatic int exp_res(input int code, input int ack);
    if (code == 0) return ack ? 1 : 0;
    if (code == 8) return 2;
    if (code == 2) return 3;
    return 4;
  endfunction

  task automatic wr(input int a, input int d);
    wr_en = 1'b1; wr_addr = 3'(a); wr_data = 8'(d);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic pulse(input int e, input int code);
    radio_evt = 6'(e); radio_code = 4'(code);
    @(negedge clk);
    radio_evt = '0;
  endtask

  task automatic rd(input int a, output int v);
    rd_addr = 3'(a);
    #1;
    v = int'(rd_data);
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 40 && busy_o; i++) @(negedge clk);
  endtask

  task automatic do_abort();
    wr(5, 0);
    wait_idle();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    finish_run();
  end

  initial begin
    int v, st, msk, seed, dv, ev, ack;
    seed = $urandom(32'd4242);
    rst_n = 1'b0; wr_en = 0; wr_addr = 0; wr_data = 0; rd_addr = 0;
    radio_evt = 0; radio_code = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk("R1", "mode", mode_o, 0);
    chk("R1", "seq", seq_o, 0);
    chk("R1", "mask", mask_o, 0);
    chk("R1", "irq", irq_o, 0);
    chk("R1", "ctrl", ctrl_o, 2);
    chk("R1", "div", div_o, 15);
    chk("R1", "busy", busy_o, 0);
    chk("R1", "tx_vld", tx_res_vld_o, 0);
    chk("R1", "tmr", tmr_arm_o, 0);
    chk("R1", "flt", flt_o, 0);
    rd(2, v); chk("R1", "status", v, 0);

    // R2 sequence codes
    begin
      int codes[5] = '{3, 4, 5, 6, 0};
      int modes[5] = '{1, 2, 3, 4, 0};
      for (int k = 0; k < 5; k++) begin
        wr(0, codes[k]);
        chk("R2", "seq", seq_o, codes[k]);
        chk("R2", "mode", mode_o, modes[k]);
        chk("R2", "seq_start", seq_start_o, codes[k] != 0);
      end
    end
    wr(0, 6);
    wr(0, 7);
    chk("R2", "bad code seq", seq_o, 6);
    chk("R2", "bad code mode", mode_o, 4);
    chk("R2", "bad code start", seq_start_o, 0);
    wr(0, 8'h13);
    chk("R2", "upper bits seq", seq_o, 6);
    wr(0, 1);
    chk("R2", "code1 mode", mode_o, 4);

    // R3 interrupts, clear-channel mode so nothing is handled in hardware
    st = 0; msk = 0;
    for (int k = 0; k < 24; k++) begin
      case ($urandom % 3)
        0: begin msk = $urandom % 64; wr(1, msk); end
        1: begin ev = $urandom % 64; pulse(ev, $urandom % 16); st |= ev; end
        default: begin ev = $urandom % 64; wr(2, ev); st &= ~ev; end
      endcase
      rd(2, v);
      chk("R3", "status", v, st);
      chk("R3", "irq", irq_o, (st & msk) != 0);
    end
    wr(2, 8'h3F); st = 0;
    rd(2, v); chk("R3", "clear all", v, 0);
    wr_en = 1; wr_addr = 2; wr_data = 8'h21; radio_evt = 6'h01;
    @(negedge clk);
    wr_en = 0; radio_evt = 0;
    rd(2, v); chk("R3", "set beats clear", v, 1);
    wr(1, 1);
    chk("R3", "irq masked in", irq_o, 1);
    wr(1, 2);
    chk("R3", "irq masked out", irq_o, 0);
    do_abort();

    // R4 abort order
    for (int it = 0; it < 3; it++) begin
      wr(0, 6);
      dv = ($urandom % 254) + 2;
      msk = ($urandom % 63) + 1;
      ev = ($urandom % 63) + 1;
      wr(3, dv); wr(1, msk); wr(4, 8'h04); pulse(ev, 0);
      rd_addr = 2;
      wr(5, 0);
      for (int idx = 0; idx <= 10; idx++) begin
        if (idx > 0) @(negedge clk);
        #1;
        chk("R4", "div", div_o, (idx >= 2 && idx < 9) ? 1 : dv);
        chk("R4", "mask", mask_o, (idx >= 3) ? 0 : msk);
        chk("R4", "status", rd_data, (idx >= 4) ? 0 : ev);
        chk("R4", "seq", seq_o, (idx >= 5) ? 0 : 6);
        chk("R4", "ctrl", ctrl_o, (idx == 6) ? 3 : 2);
        chk("R4", "tmr", tmr_arm_o, (idx >= 8) ? 0 : 1);
        chk("R4", "busy", busy_o, idx < 10);
      end
      chk("R5", "mode after abort", mode_o, 0);
    end

    // R6/R7 transmit result map and return to receive
    for (int code = 0; code < 16; code++) begin
      for (ack = 0; ack < 2; ack++) begin
        wr(4, ack);
        wr(0, 4);
        pulse(1, code);
        chk("R6", "tx_vld", tx_res_vld_o, 1);
        chk("R6", $sformatf("result code=%0d ack=%0d", code, ack), tx_res_o, exp_res(code, ack));
        chk("R7", "busy after tx", busy_o, 1);
        wait_idle();
        chk("R7", "mode rx", mode_o, 1);
        chk("R7", "seq rx", seq_o, 3);
        chk("R7", "mask rx", mask_o, 8'h25);
        chk("R7", "filters", flt_o, 7);
        chk("R7", "seq_start", seq_start_o, 1);
      end
    end

    // R9 frame match in receive mode (now in receive)
    wr(4, 8'h02);
    pulse(6'h20, 0);
    chk("R9", "ack_pend set", ack_pend_o, 1);
    chk("R9", "ack_ovr", ack_ovr_o, 1);
    rd(2, v); chk("R9", "match not kept", v & 8'h20, 0);
    wr(4, 8'h00);
    pulse(6'h20, 0);
    chk("R9", "ack_pend clear", ack_pend_o, 0);
    chk("R9", "ack_ovr kept", ack_ovr_o, 1);
    wr(0, 6);
    pulse(6'h20, 0);
    rd(2, v); chk("R9", "match in cca", v & 8'h20, 8'h20);
    do_abort();
    chk("R9", "abort clears ovr", ack_ovr_o, 0);

    // R5 abort beats completion, writes and events ignored while busy
    wr(0, 4);
    wr_en = 1; wr_addr = 5; wr_data = 0; radio_evt = 6'h01; radio_code = 0;
    @(negedge clk);
    wr_en = 0; radio_evt = 0;
    chk("R5", "no tx result", tx_res_vld_o, 0);
    wr(1, 8'h3F);
    pulse(6'h3F, 0);
    wait_idle();
    chk("R5", "mode off", mode_o, 0);
    chk("R5", "mask write ignored", mask_o, 0);
    rd(2, v); chk("R5", "events ignored", v, 0);

    // R8 energy detect re-arm
    wr(1, 8'h3E);
    wr(0, 5);
    chk("R8", "start", seq_start_o, 1);
    @(negedge clk);
    pulse(1, 0);
    chk("R8", "mask", mask_o, 1);
    chk("R8", "seq", seq_o, 5);
    chk("R8", "rearm pulse", seq_start_o, 1);
    chk("R8", "mode", mode_o, 3);
    rd(2, v); chk("R8", "status bit0", v & 1, 0);

    finish_run();
  end

endmodule